// File: doc/BRIEF.md
# Linear Transfer to INCR Burst Command Splitter

This block takes one linear memory transfer, given as a start address, a total number of beats and a beat width, and cuts it into a series of incrementing burst address commands for one read or write address channel. Each command carries an address, an 8-bit length written as beats minus one, and the beat-width code. A downstream channel master takes the commands one at a time over a valid/ready pair. The data channels, the responses and any arbitration stay outside the block.

Each burst is as long as three limits allow together: the beats still owed, a runtime cap supplied with the request, and the beats left before the next 4096-byte page edge. So no burst ever crosses a page. A transfer that fits inside one page and under the cap goes out as a single command. A one-cycle `done` pulse closes each transfer. A request whose start is not aligned to its beat width, or that asks for zero beats, is refused with a one-cycle `err` pulse and produces no command.

Back-pressure rules. On the request side, `req_ready` is high only while no transfer is in progress, and a request is taken on a rising edge where `req_valid` and `req_ready` are both high. On the command side, once `cmd_valid` is raised it stays high until a rising edge sees `cmd_ready` high. Until then `cmd_addr`, `cmd_len` and `cmd_size` do not move. `cmd_ready` may be held low for any number of cycles.

Top module: `burst_splitter`

## Requirements
- R1: `req_ready` is 1 after reset and whenever no transfer is active, and 0 from the accepting edge until the final command handshake. A request presented while `req_ready` is 0 is ignored and adds no command.
- R2: On an accepted legal request, `cmd_valid` is 1 in the cycle after the accepting edge. The first command's address equals the start address. Every command's `cmd_size` equals the request's `req_size`, where code s means 2^s bytes per beat (s = 0..7).
- R3: Each command's beat count, which is `cmd_len` + 1, equals min(beats remaining, `cfg_max_len` + 1, (4096 − (address mod 4096)) >> size).
- R4: No command crosses a 4096-byte boundary: (address mod 4096) + (`cmd_len` + 1) × 2^size ≤ 4096.
- R5: Each following command's address is the previous address plus (previous `cmd_len` + 1) × 2^size. The beat counts of one transfer add up to `req_beats`.
- R6: `cfg_max_len` is sampled at request acceptance. Changing it during a transfer does not alter that transfer's commands.
- R7: While `cmd_valid` is 1 and `cmd_ready` is 0, on the next cycle `cmd_valid` is still 1 and `cmd_addr`, `cmd_len` and `cmd_size` are unchanged.
- R8: `done` is 1 for exactly the one cycle after the edge that completes the handshake of a transfer's final command, and 0 otherwise.
- R9: A request whose `req_addr` is not a multiple of 2^`req_size`, or whose `req_beats` is 0, gives `err` = 1 for the one cycle after acceptance. It produces no command and leaves `req_ready` at 1.
- R10: With `cfg_max_len` = 255, a request of 100 beats of 4 bytes (size 2) at address 0x7871D0 goes out as one command with address 0x7871D0 and `cmd_len` 99. A cap of 255 also allows a full 256-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_max_len | input | 8 | Burst cap as beats minus one, sampled at acceptance (15 gives 16 beats) |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W (32) | Transfer start byte address |
| req_beats | input | CNT_W (16) | Total beats of the transfer |
| req_size | input | 3 | Beat width code, 2^code bytes |
| cmd_valid | output | 1 | Burst command valid |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_addr | output | ADDR_W (32) | Burst start address |
| cmd_len | output | 8 | Burst beats minus one |
| cmd_size | output | 3 | Beat width code of the burst |
| done | output | 1 | One-cycle pulse after the final command is taken |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
The first command, or the `err` pulse, is due one cycle after the edge that accepts a request. Each later command follows the edge of the previous handshake. `done` is due exactly one cycle after the edge of the final handshake. The bench drives inputs one time unit after the rising edge and samples outputs on the falling edge. A handshake seen at one falling edge therefore fixes what the next falling edge must show: the next queued command, a held command under stall, or the `done` pulse. A scoreboard queue filled from a bench model of the three length limits supplies the expected command for each handshake.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
  localparam int PAGE_BYTES = 4096;
  localparam int PAGE_W     = 12;
  localparam int LEN_W      = 8;
  localparam int SIZE_W     = 3;
  localparam int BEAT_W     = LEN_W + 1;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } bsplit_state_e;
endpackage

// File: rtl/bsplit_req_check.sv
module bsplit_req_check #(
  parameter int CNT_W = 16
) (
  input  logic [7:0]                     low_addr,
  input  logic [CNT_W-1:0]               beats,
  input  logic [bsplit_pkg::SIZE_W-1:0]  size,
  output logic                           bad
);
  logic [7:0] mask;

  always_comb begin
    mask = 8'((9'd1 << size) - 9'd1);
    bad  = (beats == '0) || ((low_addr & mask) != 8'd0);
  end
endmodule

// File: rtl/bsplit_len_calc.sv
module bsplit_len_calc #(
  parameter int CNT_W = 16
) (
  input  logic [bsplit_pkg::PAGE_W-1:0]  page_off,
  input  logic [CNT_W-1:0]               remaining,
  input  logic [bsplit_pkg::LEN_W-1:0]   max_len,
  input  logic [bsplit_pkg::SIZE_W-1:0]  size,
  output logic [bsplit_pkg::BEAT_W-1:0]  beats
);
  import bsplit_pkg::*;
  localparam int ROOM_W = PAGE_W + 1;
  localparam int CW     = (CNT_W > ROOM_W) ? CNT_W : ROOM_W;

  logic [ROOM_W-1:0] room_bytes;
  logic [ROOM_W-1:0] room_beats;
  logic [CW-1:0]     lim_rem, lim_cap, lim_page, m1, m2;

  always_comb begin
    room_bytes = ROOM_W'(PAGE_BYTES) - {1'b0, page_off};
    room_beats = room_bytes >> size;
    lim_rem    = CW'(remaining);
    lim_cap    = CW'(max_len) + CW'(1);
    lim_page   = CW'(room_beats);
    m1         = (lim_rem < lim_cap) ? lim_rem : lim_cap;
    m2         = (m1 < lim_page) ? m1 : lim_page;
    beats      = BEAT_W'(m2);
  end
endmodule

// File: rtl/burst_splitter.sv
module burst_splitter #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [bsplit_pkg::LEN_W-1:0]  cfg_max_len,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [CNT_W-1:0]              req_beats,
  input  logic [bsplit_pkg::SIZE_W-1:0] req_size,
  output logic                          cmd_valid,
  input  logic                          cmd_ready,
  output logic [ADDR_W-1:0]             cmd_addr,
  output logic [bsplit_pkg::LEN_W-1:0]  cmd_len,
  output logic [bsplit_pkg::SIZE_W-1:0] cmd_size,
  output logic                          done,
  output logic                          err
);
  import bsplit_pkg::*;

  bsplit_state_e        state;
  logic [ADDR_W-1:0]    cur_addr;
  logic [CNT_W-1:0]     remaining;
  logic [SIZE_W-1:0]    size_q;
  logic [LEN_W-1:0]     max_q;
  logic                 done_q, err_q;
  logic                 bad, accept, fire, last;
  logic [BEAT_W-1:0]    beats;

  bsplit_req_check #(.CNT_W(CNT_W)) u_check (
    .low_addr (req_addr[7:0]),
    .beats    (req_beats),
    .size     (req_size),
    .bad      (bad)
  );

  bsplit_len_calc #(.CNT_W(CNT_W)) u_len (
    .page_off  (cur_addr[PAGE_W-1:0]),
    .remaining (remaining),
    .max_len   (max_q),
    .size      (size_q),
    .beats     (beats)
  );

  always_comb begin
    req_ready = (state == ST_IDLE);
    cmd_valid = (state == ST_ISSUE);
    accept    = req_valid && req_ready;
    fire      = cmd_valid && cmd_ready;
    last      = (remaining == CNT_W'(beats));
    cmd_addr  = cur_addr;
    cmd_len   = LEN_W'(beats - BEAT_W'(1));
    cmd_size  = size_q;
    done      = done_q;
    err       = err_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      remaining <= '0;
      size_q    <= '0;
      max_q     <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= fire && last;
      err_q  <= accept && bad;
      case (state)
        ST_IDLE: begin
          if (accept && !bad) begin
            cur_addr  <= req_addr;
            remaining <= req_beats;
            size_q    <= req_size;
            max_q     <= cfg_max_len;
            state     <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (fire) begin
            cur_addr  <= cur_addr + (ADDR_W'(beats) << size_q);
            remaining <= remaining - CNT_W'(beats);
            if (last) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bsplit_checker.sv
module bsplit_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  cfg_max_len,
  input logic        req_valid,
  input logic        req_ready,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [11:0] cmd_page_off,
  input logic [7:0]  cmd_len,
  input logic [2:0]  cmd_size,
  input logic        done,
  input logic        err
);
  logic [7:0]  lim_q;
  logic [16:0] end_off;
  logic [7:0]  amask;

  always_ff @(posedge clk) begin
    if (!rst_n) lim_q <= 8'd0;
    else if (req_valid && req_ready) lim_q <= cfg_max_len;
  end

  always_comb begin
    end_off = {5'd0, cmd_page_off} + ((17'(cmd_len) + 17'd1) << cmd_size);
    amask   = 8'((9'd1 << cmd_size) - 9'd1);
  end

  AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);                                   // R1
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_len <= lim_q);                             // R3
  AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> end_off <= 17'd4096);                          // R4
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_page_off[7:0] & amask) == 8'd0);          // R5
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_page_off)
      && $stable(cmd_len) && $stable(cmd_size));                 // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                             // R8
  AST_DONE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cmd_valid && cmd_ready));                     // R8
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !cmd_valid && req_ready);                            // R9
endmodule

bind burst_splitter bsplit_checker u_bsplit_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_max_len  (cfg_max_len),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_page_off (cmd_addr[11:0]),
  .cmd_len      (cmd_len),
  .cmd_size     (cmd_size),
  .done         (done),
  .err          (err)
);

// File: tb/burst_splitter_test.sv
module burst_splitter_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        cfg_max_len = 8'd15;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CNT_W-1:0]  req_beats = '0;
  logic [2:0]        req_size = '0;
  logic              cmd_valid;
  logic              cmd_ready = 1'b1;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_len;
  logic [2:0]        cmd_size;
  logic              done, err;

  int tests = 0;
  int fails = 0;
  int done_cnt = 0;
  bit stall_on = 1'b0;
  logic [7:0] lfsr = 8'h5A;

  logic [ADDR_W-1:0] q_addr[$];
  int                q_len[$];
  int                q_size[$];
  bit                q_last[$];

  burst_splitter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_max_len(cfg_max_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_beats(req_beats), .req_size(req_size),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_size(cmd_size), .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // back-pressure driver: changes one time unit after the rising edge
  always @(posedge clk) begin
    #1;
    if (stall_on) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cmd_ready = lfsr[0] & lfsr[3];
    end else begin
      cmd_ready = 1'b1;
    end
  end

  // monitor: scoreboard compare at falling edge
  bit                hold_prev = 1'b0;
  bit                exp_done_next = 1'b0;
  logic [ADDR_W-1:0] p_addr;
  logic [7:0]        p_len;
  logic [2:0]        p_size;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev)
        chk(cmd_valid && cmd_addr == p_addr && cmd_len == p_len && cmd_size == p_size,
            "R7", "held command", {cmd_valid, cmd_addr}, {1'b1, p_addr});
      if (exp_done_next || done) begin
        chk(done == exp_done_next, "R8", "done pulse", done, exp_done_next);
        if (done) done_cnt++;
      end
      exp_done_next = 1'b0;
      hold_prev = cmd_valid && !cmd_ready;
      p_addr = cmd_addr; p_len = cmd_len; p_size = cmd_size;
      if (cmd_valid && cmd_ready) begin
        if (q_addr.size() == 0) begin
          chk(1'b0, "R1", "unexpected command", cmd_addr, 0);
        end else begin
          chk(cmd_addr == q_addr[0], "R5", "command address", cmd_addr, q_addr[0]);
          chk(int'(cmd_len) == q_len[0], "R3", "command length", cmd_len, q_len[0]);
          chk(int'(cmd_size) == q_size[0], "R2", "command size", cmd_size, q_size[0]);
          exp_done_next = q_last[0];
          void'(q_addr.pop_front()); void'(q_len.pop_front());
          void'(q_size.pop_front()); void'(q_last.pop_front());
        end
      end
    end
  end

  // bench model of the three length limits (R3, R4)
  task automatic push_model(input logic [ADDR_W-1:0] a0, input int beats,
                            input int sz, input int mx);
    longint a;
    int rem;
    a = a0; rem = beats;
    while (rem > 0) begin
      int pg;
      int b;
      pg = (4096 - int'(a % 4096)) >> sz;
      b = rem;
      if (b > mx + 1) b = mx + 1;
      if (b > pg) b = pg;
      q_addr.push_back(a[ADDR_W-1:0]);
      q_len.push_back(b - 1);
      q_size.push_back(sz);
      q_last.push_back(rem == b);
      a = a + (longint'(b) << sz);
      rem = rem - b;
    end
  endtask

  task automatic run_req(input logic [ADDR_W-1:0] a, input int beats, input int sz,
                         input int mx, input bit bad, input bit poke);
    int d0;
    d0 = done_cnt;
    cfg_max_len = 8'(mx);
    if (!bad) push_model(a, beats, sz, mx);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = a; req_beats = CNT_W'(beats); req_size = 3'(sz); req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk(err == bad, "R9", "err after accept", err, bad);
    chk(cmd_valid == !bad, "R2", "cmd_valid after accept", cmd_valid, !bad);
    if (bad) begin
      @(negedge clk);
      chk(!err && !cmd_valid && req_ready, "R9", "idle after refusal",
          {err, cmd_valid, req_ready}, 3'b001);
    end else begin
      if (poke) begin
        cfg_max_len = 8'd2;                       // R6: must not affect this transfer
        req_addr = 32'h0000_8000; req_beats = 16'd5; req_valid = 1'b1;
        for (int i = 0; i < 2; i++) begin
          chk(!req_ready, "R1", "busy refuses request", req_ready, 0);
          @(negedge clk);
        end
        req_valid = 1'b0;
      end
      wait (done_cnt != d0);
      @(negedge clk);
      chk(q_addr.size() == 0, "R5", "all bursts issued", q_addr.size(), 0);
      chk(req_ready, "R1", "idle after done", req_ready, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !cmd_valid && !done && !err, "R1", "reset state",
        {req_ready, cmd_valid, done, err}, 4'b1000);

    run_req(32'h0000_1000, 10, 2, 15, 0, 0);        // R2 single short burst
    run_req(32'h0000_0000, 40, 2, 15, 0, 0);        // R3 cap split 16/16/8
    run_req(32'h0000_0FF0, 10, 2, 255, 0, 0);       // R4 page split 4/6
    run_req(32'h0078_71D0, 100, 2, 255, 0, 0);      // R10 one burst, len 99
    run_req(32'h0001_0000, 300, 2, 255, 0, 0);      // R10 256-beat burst
    stall_on = 1'b1;
    run_req(32'h0000_3F80, 600, 0, 255, 0, 0);      // R4 R7 byte beats under stall
    run_req(32'h0000_0080, 50, 7, 255, 0, 0);       // R4 128-byte beats
    run_req(32'h0002_0F00, 200, 3, 31, 0, 1);       // R1 R6 busy poke
    stall_on = 1'b0;
    run_req(32'h0000_0002, 8, 2, 15, 1, 0);         // R9 misaligned
    run_req(32'h0000_0100, 0, 2, 15, 1, 0);         // R9 zero beats
    run_req(32'h0000_0003, 5, 0, 15, 0, 0);         // R2 byte size any alignment

    repeat (3) @(negedge clk);
    chk(q_addr.size() == 0 && !cmd_valid, "R5", "no leftover commands",
        q_addr.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule